// File: doc/BRIEF.md
# Polarity-Correcting GPIO Bank

This block is a bank of up to 32 general-purpose I/O lines controlled through a small 32-bit register bus. The bus has a write strobe, a read strobe, a byte address and write data. Software sets, for each line, the value to drive, the direction, whether the line blinks, and whether its sensed level is inverted. Software reads back the sensed level of every line through a view that is already corrected for polarity.

The pad side uses three separate vectors: the value to drive, a per-line output enable, and the raw sampled input. Every raw input passes through a synchronizer chain before the per-line polarity bit is XORed in. The corrected vector is exported on its own port, so a neighbouring interrupt block can use the same levels that software reads.

A free-running prescaler sets a common blink phase. For a driven line that has blinking enabled, the line toggles while its output data bit is 1 and stays at 0 while that bit is 0.

Top module: `gpio_bank`

## Requirements
- R1: After a synchronous active-low reset, the output-data, blink-enable and polarity registers read 0, and the direction register reads all ones. Every line is then an input, so `pin_oe` is all zeros and `pin_out` is all zeros.
- R2: The registers at byte offsets 0x00 (output data), 0x04 (direction), 0x08 (blink enable) and 0x0C (polarity) store a full word written to them, one bit per line with bit i belonging to line i. Each reads back the stored value.
- R3: A direction bit of 1 makes its line an input (`pin_oe` bit 0). A direction bit of 0 sets `pin_oe` for that line, and the line then drives its output-data bit on `pin_out` when blinking is off. The new state is visible on the pins in the cycle after the write edge.
- R4: Each bit of `pin_in` passes through two flops. A change on a pin becomes visible on `line_level`, and in reads of offset 0x10, after the second rising clock edge, and not after the first.
- R5: The input-data view at offset 0x10 and the `line_level` port equal the synchronized pin value XOR the polarity register, bit by bit. A polarity bit of 0 passes the level unchanged and a polarity bit of 1 inverts it.
- R6: Writes to offset 0x10 and to any unmapped offset change no register. Reads of any offset other than the five word offsets (including 0x14, 0xFC and misaligned offsets such as 0x02) return 0.
- R7: For a line with direction 0, blink enable 1 and output data 1, `pin_out` toggles every BLINK_HALF cycles. Over any window of 2*BLINK_HALF consecutive cycles, the line is high for exactly BLINK_HALF cycles.
- R8: A blinking line whose output-data bit is 0 stays at 0. A line whose blink-enable bit is 0 holds its output-data value steadily.
- R9: `bus_rdata` takes the addressed value in the cycle after a read strobe. It holds that value while no read is strobed, even if the pins or registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe for one cycle |
| bus_rd_en | input | 1 | Read strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | NUM_LINES | Raw pad input levels |
| pin_out | output | NUM_LINES | Values to drive on the pads |
| pin_oe | output | NUM_LINES | Per-line output enable, 1 means drive |
| line_level | output | NUM_LINES | Synchronized, polarity-corrected levels for the interrupt logic |

## Verification
A corrupted direction or output-data register shows on `pin_oe` or `pin_out` in the cycle after the write that should have set it, and it can be read back on the next read. A wrong synchronizer depth or a missing polarity XOR shows on `line_level` two edges after a pin change: the value arrives one edge early or late, or arrives inverted. A stuck or mis-divided blink prescaler only becomes visible over a whole 2*BLINK_HALF window, so the bench counts high cycles over that span instead of sampling single points.

// File: rtl/gpio_bank_pkg.sv
// Shared constants and the address decoder for the GPIO bank.
// Assumes a byte-addressed bus with word-aligned registers.
package gpio_bank_pkg;
    localparam int unsigned BUS_ADDR_W = 8;
    localparam int unsigned BUS_DATA_W = 32;

    localparam logic [BUS_ADDR_W-1:0] OFS_DOUT  = 8'h00;
    localparam logic [BUS_ADDR_W-1:0] OFS_DIR   = 8'h04;
    localparam logic [BUS_ADDR_W-1:0] OFS_BLINK = 8'h08;
    localparam logic [BUS_ADDR_W-1:0] OFS_POL   = 8'h0C;
    localparam logic [BUS_ADDR_W-1:0] OFS_LEVEL = 8'h10;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DOUT,
        SEL_DIR,
        SEL_BLINK,
        SEL_POL,
        SEL_LEVEL
    } reg_sel_e;

    // Maps a byte address to a register select; anything else is unmapped.
    function automatic reg_sel_e decode_addr(input logic [BUS_ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_DOUT:  s = SEL_DOUT;
            OFS_DIR:   s = SEL_DIR;
            OFS_BLINK: s = SEL_BLINK;
            OFS_POL:   s = SEL_POL;
            OFS_LEVEL: s = SEL_LEVEL;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_blink.sv
// Free-running prescaler that produces a square blink phase.
// The phase toggles every HALF_PERIOD cycles and is 0 out of reset.
module gpio_blink #(
    parameter int unsigned HALF_PERIOD = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    localparam int unsigned CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             phase_q;

    // Count one half period and flip the phase at its end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            phase_q <= 1'b0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            phase_q <= ~phase_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/gpio_regs.sv
// Register file of the GPIO bank: four writable per-line registers and
// a read-only level view, with a registered read port.
// Assumes NUM_LINES <= DATA_W; upper write bits are dropped and upper
// read bits return zero.
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned DATA_W    = BUS_DATA_W,
    parameter int unsigned ADDR_W    = BUS_ADDR_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_LINES-1:0] level,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_LINES-1:0] dout_q,
    output logic [NUM_LINES-1:0] dir_q,
    output logic [NUM_LINES-1:0] blink_q,
    output logic [NUM_LINES-1:0] pol_q
);
    reg_sel_e               sel;
    logic [NUM_LINES-1:0]   wline;
    logic [DATA_W-1:0]      rd_mux;

    assign sel   = decode_addr(addr);
    assign wline = wdata[NUM_LINES-1:0];

    // Update the addressed writable register; level view ignores writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q  <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_DOUT:  dout_q  <= wline;
                SEL_DIR:   dir_q   <= wline;
                SEL_BLINK: blink_q <= wline;
                SEL_POL:   pol_q   <= wline;
                default:   ;
            endcase
        end
    end

    // Select the read value; unmapped offsets give zero.
    always_comb begin
        case (sel)
            SEL_DOUT:  rd_mux = DATA_W'(dout_q);
            SEL_DIR:   rd_mux = DATA_W'(dir_q);
            SEL_BLINK: rd_mux = DATA_W'(blink_q);
            SEL_POL:   rd_mux = DATA_W'(pol_q);
            SEL_LEVEL: rd_mux = DATA_W'(level);
            default:   rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/gpio_bank.sv
// GPIO bank top: synchronizes pad inputs, applies per-line polarity,
// drives pads from output data with optional blinking, and exposes
// the registers on a simple bus.
// Assumes pads are bidirectional cells driven by pin_out/pin_oe.
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BLINK_HALF  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr_en,
    input  logic                  bus_rd_en,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic [BUS_DATA_W-1:0] bus_wdata,
    output logic [BUS_DATA_W-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0]  pin_in,
    output logic [NUM_LINES-1:0]  pin_out,
    output logic [NUM_LINES-1:0]  pin_oe,
    output logic [NUM_LINES-1:0]  line_level
);
    logic [NUM_LINES-1:0] sync_lvl;
    logic [NUM_LINES-1:0] dout_q;
    logic [NUM_LINES-1:0] dir_q;
    logic [NUM_LINES-1:0] blink_q;
    logic [NUM_LINES-1:0] pol_q;
    logic                 blink_phase;

    gpio_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (sync_lvl)
    );

    gpio_blink #(
        .HALF_PERIOD (BLINK_HALF)
    ) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (blink_phase)
    );

    gpio_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (BUS_DATA_W),
        .ADDR_W    (BUS_ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en),
        .rd_en   (bus_rd_en),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .level   (line_level),
        .rdata   (bus_rdata),
        .dout_q  (dout_q),
        .dir_q   (dir_q),
        .blink_q (blink_q),
        .pol_q   (pol_q)
    );

    // Per-line pad drive: polarity fix on input, blink gating on output.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        assign line_level[i] = sync_lvl[i] ^ pol_q[i];
        assign pin_out[i]    = dout_q[i] & ~(blink_q[i] & blink_phase);
        assign pin_oe[i]     = ~dir_q[i];
    end
endmodule

// File: rtl/gpio_bank_chk.sv
// Assertion checker for gpio_bank, attached with bind.
// Assumes the synchronous active-low reset of the bank.
module gpio_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr_en,
    input logic                  bus_rd_en,
    input logic [BUS_ADDR_W-1:0] bus_addr,
    input logic [BUS_DATA_W-1:0] bus_wdata,
    input logic [BUS_DATA_W-1:0] bus_rdata,
    input logic [NUM_LINES-1:0]  pin_in,
    input logic [NUM_LINES-1:0]  pin_out,
    input logic [NUM_LINES-1:0]  pin_oe,
    input logic [NUM_LINES-1:0]  line_level,
    input logic [NUM_LINES-1:0]  dout_q,
    input logic [NUM_LINES-1:0]  dir_q,
    input logic [NUM_LINES-1:0]  blink_q,
    input logic [NUM_LINES-1:0]  pol_q
);
    logic [1:0] since_rst;
    logic       rst_seen;

    // Count edges since reset release, saturating, for history guards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
            rst_seen  <= 1'b1;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    // R1: first cycle out of reset has no driven line.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && since_rst == 2'd0) |-> (pin_oe == '0 && pin_out == '0));

    // R3: a direction write shows on the enables one cycle later.
    assert_dir_to_oe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == OFS_DIR) |=>
            (pin_oe == ~$past(bus_wdata[NUM_LINES-1:0])));

    // R8: with blinking off, a data write lands on the pins steadily.
    assert_dout_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == OFS_DOUT && blink_q == '0) |=>
            (pin_out == $past(bus_wdata[NUM_LINES-1:0])));

    // R6: writes to the level view modify no register.
    assert_level_ro_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == OFS_LEVEL) |=>
            ($stable(dout_q) && $stable(dir_q) && $stable(blink_q) && $stable(pol_q)));

    // R6: unmapped reads return zero.
    assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && decode_addr(bus_addr) == SEL_NONE) |=> (bus_rdata == '0));

    // R9: read data holds while no read is strobed.
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_en && since_rst != 2'd0) |=> $stable(bus_rdata));

    // R4, R5: corrected level is the pin two edges back XOR polarity.
    if (SYNC_STAGES == 2) begin : g_lat
        assert_sync_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd2) |-> (line_level == ($past(pin_in, 2) ^ pol_q)));
    end
endmodule

bind gpio_bank gpio_bank_chk #(
    .NUM_LINES   (NUM_LINES),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pin_in     (pin_in),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .line_level (line_level),
    .dout_q     (dout_q),
    .dir_q      (dir_q),
    .blink_q    (blink_q),
    .pol_q      (pol_q)
);

// File: tb/sim_gpio_bank.sv
// Directed bench for gpio_bank: one task per scenario.
module sim_gpio_bank;
    localparam int unsigned NL   = 32;
    localparam int unsigned HALF = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr_en = 1'b0;
    logic          bus_rd_en = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out;
    logic [NL-1:0] pin_oe;
    logic [NL-1:0] line_level;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    gpio_bank #(.NUM_LINES(NL), .SYNC_STAGES(2), .BLINK_HALF(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .line_level(line_level)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd_en = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(8'h00, v); check(v, 32'h0, "R1 dout reset");
        bus_read(8'h04, v); check(v, 32'hFFFF_FFFF, "R1 dir reset");
        bus_read(8'h08, v); check(v, 32'h0, "R1 blink reset");
        bus_read(8'h0C, v); check(v, 32'h0, "R1 pol reset");
        check(pin_oe, 32'h0, "R1 oe reset");
        check(pin_out, 32'h0, "R1 pin_out reset");
    endtask

    task automatic t_readback();
        logic [31:0] v;
        bus_write(8'h00, 32'hC3A5_0F96); bus_read(8'h00, v); check(v, 32'hC3A5_0F96, "R2 dout");
        bus_write(8'h04, 32'h1234_FEDC); bus_read(8'h04, v); check(v, 32'h1234_FEDC, "R2 dir");
        bus_write(8'h08, 32'h8000_0001); bus_read(8'h08, v); check(v, 32'h8000_0001, "R2 blink");
        bus_write(8'h0C, 32'h5555_AAAA); bus_read(8'h0C, v); check(v, 32'h5555_AAAA, "R2 pol");
        bus_write(8'h08, 32'h0);
        bus_write(8'h0C, 32'h0);
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h00, 32'h0);
    endtask

    task automatic t_direction();
        bus_write(8'h00, 32'hA5A5_5A5A);
        bus_write(8'h04, 32'hFFFF_0000);
        check(pin_oe, 32'h0000_FFFF, "R3 oe low half");
        check({16'h0, pin_out[15:0]}, 32'h0000_5A5A, "R3 driven value");
        bus_write(8'h04, 32'hFFFF_FFFF);
        check(pin_oe, 32'h0, "R3 all inputs");
    endtask

    task automatic t_input();
        logic [31:0] v;
        @(negedge clk); pin_in = 32'h1234_5678;
        @(negedge clk); check(line_level, 32'h0, "R4 not after one edge");
        @(negedge clk); check(line_level, 32'h1234_5678, "R4 after two edges");
        bus_read(8'h10, v); check(v, 32'h1234_5678, "R4 level read");
    endtask

    task automatic t_polarity();
        logic [31:0] v;
        bus_write(8'h0C, 32'hFFFF_0000);
        bus_read(8'h10, v); check(v, 32'hEDCB_5678, "R5 inverted upper");
        check(line_level, 32'hEDCB_5678, "R5 line_level port");
        bus_write(8'h0C, 32'h0);
        check(line_level, 32'h1234_5678, "R5 pass through");
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        bus_write(8'h00, 32'h0000_00F0);
        bus_write(8'h10, 32'hDEAD_BEEF);
        bus_read(8'h10, v); check(v, 32'h1234_5678, "R6 level unchanged");
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'hFFFF_FFFF);
        bus_read(8'h00, v); check(v, 32'h0000_00F0, "R6 dout untouched");
        bus_read(8'h0C, v); check(v, 32'h0, "R6 pol untouched");
        bus_read(8'h14, v); check(v, 32'h0, "R6 unmapped 0x14");
        bus_read(8'h02, v); check(v, 32'h0, "R6 misaligned 0x02");
        bus_read(8'hFC, v); check(v, 32'h0, "R6 unmapped 0xFC");
    endtask

    task automatic t_blink();
        int hi0 = 0;
        int changes1 = 0;
        int hi2 = 0;
        logic prev1;
        bus_write(8'h00, 32'h0000_0003);
        bus_write(8'h08, 32'h0000_0005);
        bus_write(8'h04, 32'hFFFF_FFF8);
        prev1 = pin_out[1];
        for (int c = 0; c < 2 * HALF; c++) begin
            @(negedge clk);
            if (pin_out[0]) hi0++;
            if (pin_out[2]) hi2++;
            if (pin_out[1] != prev1) changes1++;
            prev1 = pin_out[1];
        end
        check(hi0, HALF, "R7 blink duty");
        check(hi2, 0, "R8 blink with data 0");
        check(changes1, 0, "R8 non-blink steady");
        check({31'h0, prev1}, 32'h1, "R8 non-blink level");
        bus_write(8'h08, 32'h0);
        bus_write(8'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        bus_read(8'h10, v);
        @(negedge clk); pin_in = 32'h0F0F_0F0F;
        bus_write(8'h00, 32'h1);
        repeat (4) @(negedge clk);
        check(bus_rdata, v, "R9 rdata holds");
        bus_read(8'h10, v); check(v, 32'h0F0F_0F0F, "R9 new read");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_direction();
        t_input();
        t_polarity();
        t_readonly();
        t_blink();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule